// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces one pulse per period on a single output pin from a 16-bit up-counter and two compare values. A period value sets where each period ends and an edge value sets where inside the period the output first leaves its idle level. The counter advances once for each count-enable tick. A prescaler outside the block supplies these ticks. At the edge match the output moves to the level opposite the programmed idle level. At the period match it returns to idle, a one-cycle interrupt pulse is raised and the counter restarts from zero.

Software drives the block through three write strobes. One strobe carries the control fields: run, one-shot, idle level and double-buffer enable. The other two carry the period value and the edge value. In continuous mode the pulse train repeats until software clears run. In one-shot mode the block clears run by itself at the period match. The one-shot select can be changed while the timer runs. The idle level and the double-buffer enable are locked while it runs. With double buffering on, compare writes made while running wait in shadow registers until the next period match. Otherwise they act at once, and a value already passed by the counter makes the counter run on through wraparound.

Top module: `pulse_timer`

## Requirements
- R1: After reset, pulse_out, irq and running are all 0. The period value resets to 0xFFFF, the edge value resets to 0, and the idle level resets to low.
- R2: While running is 0, the counter stays at zero, ticks have no effect, irq stays 0 and pulse_out equals the programmed idle level. A control write made while stopped updates that idle level at once.
- R3: On a clock edge where running is 1, tick is 1 and the count equals the edge value, pulse_out moves to the inverse of the idle level.
- R4: On a clock edge where running is 1, tick is 1 and the count equals the period value P, pulse_out returns to idle, irq is 1 for exactly the following cycle and the count returns to 0. With tick held at 1, irq repeats every P+1 cycles, and pulse_out is active for P minus E cycles per period, where E is the edge value.
- R5: In one-shot mode the period match also clears running on the same edge. After that no further irq occurs.
- R6: A control write with run=0 clears running and drives pulse_out to the idle level on the same clock edge.
- R7: A control write with run=1 while running changes only the one-shot select. Clearing it cancels a pending one-shot stop. Setting it stops the timer at the next period match.
- R8: With double buffering on, compare writes made while running take effect only at the next period match. Writes made while stopped take effect at once.
- R9: With double buffering off, compare writes take effect on the next edge. A period value below the current count makes the counter run on to 0xFFFF, wrap to 0 and match on the next real equality.
- R10: Control writes made while running leave the idle level and the double-buffer enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_run | input | 1 | Run bit written with ctrl_we |
| ctrl_oneshot | input | 1 | One-shot select written with ctrl_we |
| ctrl_idle_hi | input | 1 | Idle level (1 = high), accepted only while stopped |
| ctrl_dbuf | input | 1 | Double-buffer enable, accepted only while stopped |
| per_we | input | 1 | Period value write strobe |
| per_val | input | 16 | Period compare value |
| edge_we | input | 1 | Edge value write strobe |
| edge_val | input | 16 | Edge compare value |
| tick | input | 1 | Prescaled count enable |
| pulse_out | output | 1 | Pulse output |
| irq | output | 1 | One-cycle period-match interrupt pulse |
| running | output | 1 | Run status |

## Verification
The assertions check several rules on every cycle. The counter is held at zero and the output sits at the idle level whenever the timer is stopped. Every interrupt leaves the counter at zero and lasts exactly one cycle. An edge match drives the output active, a software stop or a one-shot period match clears running, and the idle level never changes while the timer runs. Other behaviour depends on the timing of writes against the count, and only the bench scenarios show it. These are the exact period and pulse width for several compare settings, the delayed reload under double buffering, the wrap of a lowered period value through 0xFFFF, and the one-shot select being switched while the timer runs.

// File: rtl/pg_pkg.sv
// Shared definitions for the pulse timer: compare channel indices and the
// control write bundle. Assumes two compare channels (period and edge).
package pg_pkg;
    localparam int NUM_CH    = 2;
    localparam int CH_PERIOD = 0;
    localparam int CH_EDGE   = 1;

    typedef struct packed {
        logic run;
        logic oneshot;
        logic idle_hi;
        logic dbuf;
    } pg_ctrl_t;
endpackage

// File: rtl/pg_ctrl.sv
// Control state of the pulse timer: run bit, one-shot select, idle level
// and double-buffer enable. Idle level and buffering are accepted only
// while stopped. A software write to run wins over the one-shot auto-stop.
module pg_ctrl
    import pg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_we,
    input  pg_ctrl_t wr,
    input  logic     match_a,
    output logic     run_q,
    output logic     run_nxt,
    output logic     oneshot_q,
    output logic     idle_q,
    output logic     idle_nxt,
    output logic     dbuf_q
);
    // next run and idle-level values, shared with counter and output stage
    always_comb begin
        run_nxt = run_q;
        if (ctrl_we)
            run_nxt = wr.run;
        else if (match_a && oneshot_q)
            run_nxt = 1'b0;
        idle_nxt = (ctrl_we && !run_q) ? wr.idle_hi : idle_q;
    end

    // control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            oneshot_q <= 1'b0;
            idle_q    <= 1'b0;
            dbuf_q    <= 1'b0;
        end else begin
            run_q  <= run_nxt;
            idle_q <= idle_nxt;
            if (ctrl_we)
                oneshot_q <= wr.oneshot;
            if (ctrl_we && !run_q)
                dbuf_q <= wr.dbuf;
        end
    end
endmodule

// File: rtl/pg_cmp_bank.sv
// Compare value bank: one shadow and one active register per channel.
// A write loads the active value directly when load_now is set, otherwise
// only the shadow; reload copies every shadow into its active register.
module pg_cmp_bank
    import pg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            wr_en,
    input  logic [NUM_CH-1:0][CNT_W-1:0] wr_val,
    input  logic                         load_now,
    input  logic                         reload,
    output logic [NUM_CH-1:0][CNT_W-1:0] act
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [CNT_W-1:0] RST_V = (g == CH_PERIOD) ? {CNT_W{1'b1}} : '0;
        logic [CNT_W-1:0] shadow_q;
        logic [CNT_W-1:0] act_q;

        // shadow copy always follows writes
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q <= RST_V;
            else if (wr_en[g])
                shadow_q <= wr_val[g];
        end

        // active value: direct write or reload from shadow
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_q <= RST_V;
            else if (wr_en[g] && load_now)
                act_q <= wr_val[g];
            else if (reload)
                act_q <= shadow_q;
        end

        assign act[g] = act_q;
    end
endmodule

// File: rtl/pg_counter.sv
// Up-counter with equality matches against the period and edge values.
// Matches are evaluated on the pre-increment count of a ticking cycle;
// the count is held at zero whenever the timer is (or is becoming) stopped.
module pg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q,
    input  logic             run_nxt,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match_a,
    output logic             match_b
);
    // match detection on ticking cycles only
    always_comb begin
        match_a = run_q && tick && (cnt_q == cmp_a);
        match_b = run_q && tick && (cnt_q == cmp_b);
    end

    // count register, natural wrap at all ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_nxt || match_a)
            cnt_q <= '0;
        else if (run_q && tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pg_out.sv
// Output stage: pulse pin register and interrupt pulse. The pin takes the
// idle level on the same edge that the timer stops; period match beats
// edge match if both hit together.
module pg_out (
    input  logic clk,
    input  logic rst_n,
    input  logic run_nxt,
    input  logic idle_q,
    input  logic idle_nxt,
    input  logic match_a,
    input  logic match_b,
    output logic pulse_out,
    output logic irq
);
    // pulse pin and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= match_a;
            if (!run_nxt)
                pulse_out <= idle_nxt;
            else if (match_a)
                pulse_out <= idle_q;
            else if (match_b)
                pulse_out <= ~idle_q;
        end
    end
endmodule

// File: rtl/pulse_timer.sv
// Programmable pulse generator timer top. Assumes the period value is
// larger than the edge value and that tick is already prescaled.
module pulse_timer
    import pg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_run,
    input  logic             ctrl_oneshot,
    input  logic             ctrl_idle_hi,
    input  logic             ctrl_dbuf,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_val,
    input  logic             edge_we,
    input  logic [CNT_W-1:0] edge_val,
    input  logic             tick,
    output logic             pulse_out,
    output logic             irq,
    output logic             running
);
    pg_ctrl_t                    wr;
    logic                        run_q, run_nxt, oneshot_q, idle_q, idle_nxt, dbuf_q;
    logic [CNT_W-1:0]            cnt_q;
    logic                        match_a, match_b;
    logic [NUM_CH-1:0]           cmp_we;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_wval;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;

    // bundle write-port fields
    always_comb begin
        wr                  = '{run: ctrl_run, oneshot: ctrl_oneshot,
                                idle_hi: ctrl_idle_hi, dbuf: ctrl_dbuf};
        cmp_we[CH_PERIOD]   = per_we;
        cmp_we[CH_EDGE]     = edge_we;
        cmp_wval[CH_PERIOD] = per_val;
        cmp_wval[CH_EDGE]   = edge_val;
    end

    pg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wr(wr), .match_a(match_a),
        .run_q(run_q), .run_nxt(run_nxt), .oneshot_q(oneshot_q),
        .idle_q(idle_q), .idle_nxt(idle_nxt), .dbuf_q(dbuf_q)
    );

    pg_cmp_bank #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr_en(cmp_we), .wr_val(cmp_wval),
        .load_now(!dbuf_q || !run_q), .reload(match_a && dbuf_q), .act(cmp_act)
    );

    pg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .run_nxt(run_nxt), .tick(tick),
        .cmp_a(cmp_act[CH_PERIOD]), .cmp_b(cmp_act[CH_EDGE]),
        .cnt_q(cnt_q), .match_a(match_a), .match_b(match_b)
    );

    pg_out u_out (
        .clk(clk), .rst_n(rst_n), .run_nxt(run_nxt), .idle_q(idle_q),
        .idle_nxt(idle_nxt), .match_a(match_a), .match_b(match_b),
        .pulse_out(pulse_out), .irq(irq)
    );

    assign running = run_q;
endmodule

// File: rtl/pulse_timer_chk.sv
// Property checker for pulse_timer, attached by bind. Observes ports plus
// count, idle level, one-shot select and active compare values.
module pulse_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_we,
    input logic             ctrl_run,
    input logic             tick,
    input logic             pulse_out,
    input logic             irq,
    input logic             running,
    input logic             idle_lvl,
    input logic             oneshot_lvl,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] edge_act
);
    p_cnt_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> cnt_val == '0);

    p_idle_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> pulse_out == idle_lvl);

    p_edge_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !ctrl_we && cnt_val == edge_act && cnt_val != per_act)
        |=> pulse_out != idle_lvl);

    p_irq_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt_val == '0);

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(oneshot_lvl) && !$past(ctrl_we)) |-> !running);

    p_sw_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_run) |=> (!running && pulse_out == idle_lvl));

    p_idle_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(idle_lvl));
endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_run(ctrl_run),
    .tick(tick), .pulse_out(pulse_out), .irq(irq), .running(running),
    .idle_lvl(idle_q), .oneshot_lvl(oneshot_q), .cnt_val(cnt_q),
    .per_act(cmp_act[pg_pkg::CH_PERIOD]), .edge_act(cmp_act[pg_pkg::CH_EDGE])
);

// File: tb/pulse_timer_test.sv
// Self-checking bench: a vector table of compare settings walked by one
// loop, then directed tests for reset, one-shot, mode switching, double
// buffering, immediate writes with wraparound and locked fields.
module pulse_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] edg;
        logic        idle;
    } vec_t;

    localparam int   VEC_N = 4;
    localparam vec_t VECS [VEC_N] = '{
        '{per: 16'd5,  edg: 16'd2, idle: 1'b0},
        '{per: 16'd3,  edg: 16'd0, idle: 1'b1},
        '{per: 16'd10, edg: 16'd9, idle: 1'b0},
        '{per: 16'd7,  edg: 16'd3, idle: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0, ctrl_run = 1'b0, ctrl_oneshot = 1'b0;
    logic        ctrl_idle_hi = 1'b0, ctrl_dbuf = 1'b0;
    logic        per_we = 1'b0, edge_we = 1'b0;
    logic [15:0] per_val = '0, edge_val = '0;
    logic        tick = 1'b1;
    logic        pulse_out, irq, running;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    pulse_timer uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_run(ctrl_run),
        .ctrl_oneshot(ctrl_oneshot), .ctrl_idle_hi(ctrl_idle_hi),
        .ctrl_dbuf(ctrl_dbuf), .per_we(per_we), .per_val(per_val),
        .edge_we(edge_we), .edge_val(edge_val), .tick(tick),
        .pulse_out(pulse_out), .irq(irq), .running(running)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // all write tasks start and end at a falling edge, one clock each
    task automatic wr_ctrl(input logic r, input logic os, input logic ih, input logic db);
        ctrl_we = 1'b1; ctrl_run = r; ctrl_oneshot = os; ctrl_idle_hi = ih; ctrl_dbuf = db;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_per(input logic [15:0] v);
        per_we = 1'b1; per_val = v;
        @(negedge clk);
        per_we = 1'b0;
    endtask

    task automatic wr_edge(input logic [15:0] v);
        edge_we = 1'b1; edge_val = v;
        @(negedge clk);
        edge_we = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (irq) break;
            if (n > 70000) begin n = -1; break; end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        int n, first_irq, second_irq, act_cnt, irq_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pulse_out after reset", pulse_out, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 running after reset", running, 0);

        // R2: ticks ignored while stopped
        irq_seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq) irq_seen++;
        end
        chk("R2 no irq while stopped", irq_seen, 0);
        chk("R2 idle low while stopped", pulse_out, 0);
        wr_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R2 idle high applied while stopped", pulse_out, 1);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R3 R4 R6: vector table, continuous mode
        for (int v = 0; v < VEC_N; v++) begin
            wr_ctrl(1'b0, 1'b0, VECS[v].idle, 1'b0);
            wr_per(VECS[v].per);
            wr_edge(VECS[v].edg);
            wr_ctrl(1'b1, 1'b0, VECS[v].idle, 1'b0);
            first_irq = 0; second_irq = 0; act_cnt = 0;
            for (int s = 1; s <= 2 * int'(VECS[v].per) + 2; s++) begin
                @(negedge clk);
                if (irq) begin
                    if (first_irq == 0) first_irq = s;
                    else second_irq = s;
                end
                if (s <= int'(VECS[v].per) && pulse_out != VECS[v].idle) act_cnt++;
            end
            chk("R4 first irq position", first_irq, int'(VECS[v].per) + 1);
            chk("R4 second irq position", second_irq, 2 * int'(VECS[v].per) + 2);
            chk("R3 active width", act_cnt, int'(VECS[v].per) - int'(VECS[v].edg));
            chk("R4 still running", running, 1);
            wr_ctrl(1'b0, 1'b0, VECS[v].idle, 1'b0);
            chk("R6 stopped", running, 0);
            chk("R6 idle after stop", pulse_out, VECS[v].idle);
        end
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R5: one-shot
        wr_per(16'd4);
        wr_edge(16'd1);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        wait_irq(n);
        chk("R5 one-shot irq position", n, 5);
        chk("R5 running cleared at match", running, 0);
        chk("R5 idle after auto-stop", pulse_out, 0);
        irq_seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (irq) irq_seen++;
        end
        chk("R5 no irq after auto-stop", irq_seen, 0);

        // R7: one-shot cancelled, then continuous switched to one-shot
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        wait_irq(n);
        chk("R7 cancelled one-shot keeps running", running, 1);
        wait_irq(n);
        chk("R7 continuous period after cancel", n, 5);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
        wait_irq(n);
        chk("R7 switched to one-shot stops at match", running, 0);

        // R10: idle level locked while running
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        wr_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 idle level unchanged by running write", pulse_out, 0);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R8: double buffering
        wr_per(16'd6);
        wr_edge(16'd2);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        wait_irq(n);
        chk("R8 first period", n, 7);
        wr_per(16'd3);
        wr_edge(16'd1);
        wait_irq(n);
        chk("R8 old period held until match", n, 5);
        wait_irq(n);
        chk("R8 new period after match", n, 4);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R9: immediate write above the count
        wr_per(16'd20);
        wr_edge(16'd2);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        wr_per(16'd8);
        wait_irq(n);
        chk("R9 immediate period write", n, 8);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R9: immediate write below the count wraps through 0xFFFF
        wr_per(16'd20);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        wr_per(16'd5);
        wait_irq(n);
        chk("R9 wrap before match", n, 65531);
        chk("R9 running after wrap", running, 1);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        finish_run();
    end
endmodule